// File: doc/BRIEF.md
# Lookup Table Access Engine

This block lets a host reach on-chip lookup tables indirectly through a small window of 16-bit registers. To start an operation, the host first fills ten entry-data registers and an index register. It then writes a control word that names the table, the direction and, for reads of the forwarding table, a lookup method. The engine raises busy while it works. When it finishes, it leaves a hit flag and a result index in a status word. On reads it also copies the entry into ten read-data registers.

The forwarding table (table code 0) holds 64 entries. Each entry is placed at a slot found by XOR-folding its 60-bit key, which is the 48-bit station address plus a 12-bit filtering id. The table can be read in four ways:

- by key;
- by exact index;
- by walking forward from an index to the next valid entry;
- by walking forward with a filter: unicast only, multicast only, or unicast learned on one port.

Every other table code reaches one plain 8-entry RAM, which is addressed by the low index bits.

Top module: `ltbl_engine`

## Requirements
- R1: The control word sits at offset 0x00. Its fields are: table code in bits 2:0 (0 is the forwarding table); direction in bit 3 (1 write, 0 read); method in bits 6:4; port in bits 11:8. Bits 7 and 15:12 read back as zero. A write to this word while idle starts an operation.
- R2: The index register sits at offset 0x01 and holds 13 bits. Bits 15:13 read back as zero.
- R3: The status word sits at offset 0x02. Result index bits 10:0 appear in bits 10:0, index bit 12 in bit 11, hit in bit 12, busy in bit 13 and index bit 11 in bit 14. Bit 15 reads zero. After reset the whole word is zero.
- R4: Busy rises on the clock edge that takes a control write and stays high until the operation ends. A control write that arrives while busy is dropped: it neither changes the control readback nor starts anything.
- R5: The write-data words sit at offsets 0x10 to 0x19 and the read-data words at 0x20 to 0x29, with word 0 holding entry bits 15:0. Word nine keeps only 4 bits, and its bits 15:4 read as zero.
- R6: An entry is laid out as follows: bit 0 valid, bit 1 multicast, bits 5:2 port, bits 53:6 address, bits 65:54 filtering id. A forwarding-table write ignores the index register. It targets the slot given by the XOR of the ten 6-bit chunks of entry bits 65:6. If that slot is empty or holds the same key, the entry is stored, hit is set and the slot index is reported. Otherwise hit clears and the table is left unchanged.
- R7: A read with method 0 takes its key from the write-data words. It hits, reports the slot and loads the entry only when that slot is valid and holds the same key.
- R8: A read with method 1 hits only when the index is below 64 and that slot is valid. It then loads the entry.
- R9: Methods 2 to 5 look at slots strictly above the index, in increasing order, with no wrap-around. Method 2 accepts any valid slot. Method 3 accepts valid slots with the multicast bit clear. Method 4 accepts valid slots with the multicast bit set. Method 5 accepts valid slots with the multicast bit clear and a port equal to the control port field. The first slot accepted gives the hit and the entry.
- R10: Method values 6 and 7 finish with hit cleared and leave the table untouched.
- R11: An operation without a hit leaves hit at 0 and the reported index at 0. The read-data words keep their previous contents.
- R12: Table codes 1 to 7 reach one 8-entry RAM at index bits 2:0. A write stores the entry and a read loads it into the read-data words. Hit and the index both end at 0.
- R13: Every non-scanning operation holds busy for one cycle. A scan from index s holds busy for j-s+1 cycles when it accepts slot j. It holds busy for 64-s cycles when nothing matches, and for one cycle when s is 63 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 6 | Register offset for both reads and writes |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Register read data, combinational from host_addr |
| busy | output | 1 | Operation in progress (same as status bit 13) |

## Verification
Register writes take effect on the edge that samples them. Readback is combinational, so the bench reads at the falling edge after a write. Busy rises on the launch edge. The bench then counts busy cycles at each falling edge and compares the count with the length that R13 predicts: one cycle for direct operations, and a length set by the start index and the slot accepted for scans. Status, control readback and all ten read-data words are sampled only once busy has dropped, and are compared against a bench model of the table and the RAM.

// File: rtl/ltbl_pkg.sv
package ltbl_pkg;
  localparam int WORD_W  = 16;
  localparam int N_WORDS = 10;
  localparam int LAST_W  = 4;
  localparam int ENT_W   = (N_WORDS - 1) * WORD_W + LAST_W;
  localparam int IDX_W   = 13;
  localparam int MAC_W   = 48;
  localparam int FID_W   = 12;
  localparam int KEY_W   = MAC_W + FID_W;
  localparam int PORT_W  = 4;
  localparam int HOST_AW = 6;

  // entry field positions
  localparam int F_VALID = 0;
  localparam int F_MC    = 1;
  localparam int F_PORT  = 2;
  localparam int F_MAC   = F_PORT + PORT_W;

  // register window offsets
  localparam logic [HOST_AW-1:0] OFS_CTRL = 6'h00;
  localparam logic [HOST_AW-1:0] OFS_IDX  = 6'h01;
  localparam logic [HOST_AW-1:0] OFS_STAT = 6'h02;
  localparam logic [HOST_AW-1:0] OFS_WR   = 6'h10;
  localparam logic [HOST_AW-1:0] OFS_RD   = 6'h20;

  localparam logic [2:0] TBL_L2 = 3'd0;

  localparam logic [2:0] M_KEY          = 3'd0;
  localparam logic [2:0] M_INDEX        = 3'd1;
  localparam logic [2:0] M_NEXT         = 3'd2;
  localparam logic [2:0] M_NEXT_UC      = 3'd3;
  localparam logic [2:0] M_NEXT_MC      = 3'd4;
  localparam logic [2:0] M_NEXT_UC_PORT = 3'd5;

  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic [2:0]        meth;
    logic              op;
    logic [2:0]        tbl;
  } cmd_t;
endpackage

// File: rtl/ltbl_regs.sv
module ltbl_regs
  import ltbl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [WORD_W-1:0]  host_wdata,
  output logic [WORD_W-1:0]  host_rdata,
  input  logic               busy,
  input  logic               stat_hit,
  input  logic [IDX_W-1:0]   stat_idx,
  input  logic               rd_load,
  input  logic [ENT_W-1:0]   rd_ent,
  output logic               launch,
  output cmd_t               cmd,
  output logic [IDX_W-1:0]   idx_word,
  output logic [ENT_W-1:0]   wr_ent
);
  localparam int LAST_LO = (N_WORDS - 1) * WORD_W;

  cmd_t             cmd_q, cmd_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [ENT_W-1:0] wr_q, wr_d, rd_q;
  logic             idx_en, wr_en;

  assign launch = host_we && (host_addr == OFS_CTRL) && !busy;
  assign idx_en = host_we && (host_addr == OFS_IDX);

  always_comb begin
    cmd_d = '{port: host_wdata[11:8], meth: host_wdata[6:4],
              op: host_wdata[3], tbl: host_wdata[2:0]};
    idx_d = host_wdata[IDX_W-1:0];
    wr_d  = wr_q;
    wr_en = 1'b0;
    for (int i = 0; i < N_WORDS - 1; i++) begin
      if (host_we && host_addr == OFS_WR + HOST_AW'(i)) begin
        wr_d[i*WORD_W +: WORD_W] = host_wdata;
        wr_en = 1'b1;
      end
    end
    if (host_we && host_addr == OFS_WR + HOST_AW'(N_WORDS - 1)) begin
      wr_d[LAST_LO +: LAST_W] = host_wdata[LAST_W-1:0];
      wr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      idx_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
    end else begin
      if (launch)  cmd_q <= cmd_d;
      if (idx_en)  idx_q <= idx_d;
      if (wr_en)   wr_q  <= wr_d;
      if (rd_load) rd_q  <= rd_ent;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == OFS_CTRL)
      host_rdata = {4'h0, cmd_q.port, 1'b0, cmd_q.meth, cmd_q.op, cmd_q.tbl};
    else if (host_addr == OFS_IDX)
      host_rdata = WORD_W'(idx_q);
    else if (host_addr == OFS_STAT)
      host_rdata = {1'b0, stat_idx[11], busy, stat_hit, stat_idx[12], stat_idx[10:0]};
    for (int i = 0; i < N_WORDS - 1; i++) begin
      if (host_addr == OFS_WR + HOST_AW'(i)) host_rdata = wr_q[i*WORD_W +: WORD_W];
      if (host_addr == OFS_RD + HOST_AW'(i)) host_rdata = rd_q[i*WORD_W +: WORD_W];
    end
    if (host_addr == OFS_WR + HOST_AW'(N_WORDS - 1))
      host_rdata = WORD_W'(wr_q[LAST_LO +: LAST_W]);
    if (host_addr == OFS_RD + HOST_AW'(N_WORDS - 1))
      host_rdata = WORD_W'(rd_q[LAST_LO +: LAST_W]);
  end

  assign cmd      = cmd_q;
  assign idx_word = idx_q;
  assign wr_ent   = wr_q;
endmodule

// File: rtl/ltbl_l2_store.sv
module ltbl_l2_store
  import ltbl_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [ENT_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0] vld_q;
  logic [ENT_W-1:1] body_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (we) vld_q[waddr] <= wdata[F_VALID];
  end

  always_ff @(posedge clk) begin
    if (we) body_q[waddr] <= wdata[ENT_W-1:1];
  end

  assign rdata = {body_q[raddr], vld_q[raddr]};
endmodule

// File: rtl/ltbl_aux_ram.sv
module ltbl_aux_ram
  import ltbl_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [ENT_W-1:0] wdata,
  output logic [ENT_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [ENT_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/ltbl_seq.sv
module ltbl_seq
  import ltbl_pkg::*;
#(
  parameter int L2_AW  = 6,
  parameter int AUX_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  cmd_t              cmd,
  input  logic [IDX_W-1:0]  idx_word,
  input  logic [ENT_W-1:0]  wr_ent,
  output logic              busy,
  output logic              hit,
  output logic [IDX_W-1:0]  res_idx,
  output logic              rd_load,
  output logic [ENT_W-1:0]  rd_ent,
  output logic              l2_we,
  output logic [L2_AW-1:0]  l2_waddr,
  output logic [L2_AW-1:0]  l2_raddr,
  output logic [ENT_W-1:0]  l2_wdata,
  input  logic [ENT_W-1:0]  l2_rdata,
  output logic              aux_we,
  output logic [AUX_AW-1:0] aux_addr,
  output logic [ENT_W-1:0]  aux_wdata,
  input  logic [ENT_W-1:0]  aux_rdata
);
  localparam int L2_DEPTH = 1 << L2_AW;
  localparam int LAST     = L2_DEPTH - 1;
  localparam int N_CHUNK  = (KEY_W + L2_AW - 1) / L2_AW;
  localparam int PAD_W    = N_CHUNK * L2_AW;

  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_SCAN} st_e;

  st_e              st_q, st_d;
  logic [L2_AW-1:0] ptr_q, ptr_d;
  logic             hit_q, hit_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  logic [PAD_W-1:0] key_pad;
  logic [L2_AW-1:0] key_hash;
  logic             key_same, ent_ok, scan_hit, in_range, at_end;
  logic             done, found;
  logic [L2_AW-1:0] found_idx;

  // XOR fold of the key carried in the write-data words
  always_comb begin
    key_pad  = PAD_W'(wr_ent[F_MAC +: KEY_W]);
    key_hash = '0;
    for (int c = 0; c < N_CHUNK; c++) key_hash ^= key_pad[c*L2_AW +: L2_AW];
  end

  assign key_same = (l2_rdata[F_MAC +: KEY_W] == wr_ent[F_MAC +: KEY_W]);
  assign in_range = (idx_word < IDX_W'(L2_DEPTH));
  assign at_end   = (idx_word >= IDX_W'(LAST));

  always_comb begin
    case (cmd.meth)
      M_NEXT_UC:      ent_ok = !l2_rdata[F_MC];
      M_NEXT_MC:      ent_ok = l2_rdata[F_MC];
      M_NEXT_UC_PORT: ent_ok = !l2_rdata[F_MC] && (l2_rdata[F_PORT +: PORT_W] == cmd.port);
      default:        ent_ok = 1'b1;
    endcase
  end
  assign scan_hit = l2_rdata[F_VALID] && ent_ok;

  always_comb begin
    st_d      = st_q;
    ptr_d     = ptr_q;
    hit_d     = hit_q;
    idx_d     = idx_q;
    l2_raddr  = ptr_q;
    l2_we     = 1'b0;
    aux_we    = 1'b0;
    rd_load   = 1'b0;
    rd_ent    = l2_rdata;
    done      = 1'b0;
    found     = 1'b0;
    found_idx = '0;
    case (st_q)
      S_IDLE: if (launch) st_d = S_EXEC;
      S_EXEC: begin
        if (cmd.tbl != TBL_L2) begin
          done = 1'b1;
          if (cmd.op) aux_we = 1'b1;
          else begin
            rd_load = 1'b1;
            rd_ent  = aux_rdata;
          end
        end else if (cmd.op) begin
          l2_raddr = key_hash;
          done     = 1'b1;
          if (!l2_rdata[F_VALID] || key_same) begin
            l2_we     = 1'b1;
            found     = 1'b1;
            found_idx = key_hash;
          end
        end else begin
          case (cmd.meth)
            M_KEY: begin
              l2_raddr = key_hash;
              done     = 1'b1;
              if (l2_rdata[F_VALID] && key_same) begin
                found     = 1'b1;
                found_idx = key_hash;
                rd_load   = 1'b1;
              end
            end
            M_INDEX: begin
              l2_raddr = idx_word[L2_AW-1:0];
              done     = 1'b1;
              if (in_range && l2_rdata[F_VALID]) begin
                found     = 1'b1;
                found_idx = idx_word[L2_AW-1:0];
                rd_load   = 1'b1;
              end
            end
            M_NEXT, M_NEXT_UC, M_NEXT_MC, M_NEXT_UC_PORT: begin
              if (at_end) done = 1'b1;
              else begin
                ptr_d = idx_word[L2_AW-1:0] + L2_AW'(1);
                st_d  = S_SCAN;
              end
            end
            default: done = 1'b1;
          endcase
        end
      end
      S_SCAN: begin
        if (scan_hit) begin
          done      = 1'b1;
          found     = 1'b1;
          found_idx = ptr_q;
          rd_load   = 1'b1;
        end else if (ptr_q == L2_AW'(LAST)) begin
          done = 1'b1;
        end else begin
          ptr_d = ptr_q + L2_AW'(1);
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (done) begin
      st_d  = S_IDLE;
      hit_d = found;
      idx_d = found ? IDX_W'(found_idx) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      ptr_q <= '0;
      hit_q <= 1'b0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      if (done) begin
        hit_q <= hit_d;
        idx_q <= idx_d;
      end
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign hit       = hit_q;
  assign res_idx   = idx_q;
  assign l2_waddr  = key_hash;
  assign l2_wdata  = wr_ent;
  assign aux_addr  = idx_word[AUX_AW-1:0];
  assign aux_wdata = wr_ent;
endmodule

// File: rtl/ltbl_engine.sv
module ltbl_engine
  import ltbl_pkg::*;
#(
  parameter int L2_AW  = 6,
  parameter int AUX_AW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [WORD_W-1:0]  host_wdata,
  output logic [WORD_W-1:0]  host_rdata,
  output logic               busy
);
  logic              launch, hit, rd_load, l2_we, aux_we;
  cmd_t              cmd;
  logic [IDX_W-1:0]  idx_word, res_idx;
  logic [ENT_W-1:0]  wr_ent, rd_ent, l2_wdata, l2_rdata, aux_wdata, aux_rdata;
  logic [L2_AW-1:0]  l2_waddr, l2_raddr;
  logic [AUX_AW-1:0] aux_addr;

  ltbl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
    .stat_hit(hit), .stat_idx(res_idx), .rd_load(rd_load), .rd_ent(rd_ent),
    .launch(launch), .cmd(cmd), .idx_word(idx_word), .wr_ent(wr_ent)
  );

  ltbl_seq #(.L2_AW(L2_AW), .AUX_AW(AUX_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .cmd(cmd), .idx_word(idx_word),
    .wr_ent(wr_ent), .busy(busy), .hit(hit), .res_idx(res_idx),
    .rd_load(rd_load), .rd_ent(rd_ent), .l2_we(l2_we), .l2_waddr(l2_waddr),
    .l2_raddr(l2_raddr), .l2_wdata(l2_wdata), .l2_rdata(l2_rdata),
    .aux_we(aux_we), .aux_addr(aux_addr), .aux_wdata(aux_wdata), .aux_rdata(aux_rdata)
  );

  ltbl_l2_store #(.AW(L2_AW)) u_l2 (
    .clk(clk), .rst_n(rst_n), .we(l2_we), .waddr(l2_waddr), .wdata(l2_wdata),
    .raddr(l2_raddr), .rdata(l2_rdata)
  );

  ltbl_aux_ram #(.AW(AUX_AW)) u_aux (
    .clk(clk), .we(aux_we), .addr(aux_addr), .wdata(aux_wdata), .rdata(aux_rdata)
  );
endmodule

// File: rtl/ltbl_engine_chk.sv
module ltbl_engine_chk
  import ltbl_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               host_we,
  input logic [HOST_AW-1:0] host_addr,
  input logic [2:0]         new_tbl,
  input logic [WORD_W-1:0]  host_rdata,
  input logic               busy,
  input cmd_t               cmd,
  input logic               l2_we
);
  a_r4_launch_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == OFS_CTRL && !busy) |=> busy);

  a_r4_ctrl_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == OFS_CTRL && busy) |=> $stable(cmd));

  a_r6_table_write_in_op: assert property (@(posedge clk) disable iff (!rst_n)
    l2_we |-> busy);

  a_r5_tenth_word_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == OFS_WR + 6'd9 || host_addr == OFS_RD + 6'd9) |-> host_rdata[15:4] == 12'h0);

  a_r3_status_busy_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == OFS_STAT) |-> (host_rdata[13] == busy && !host_rdata[15]));

  a_r2_index_width: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == OFS_IDX) |-> host_rdata[15:13] == 3'b000);

  a_r13_direct_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == OFS_CTRL && !busy && new_tbl != TBL_L2) |=> busy ##1 !busy);
endmodule

bind ltbl_engine ltbl_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
  .new_tbl(host_wdata[2:0]), .host_rdata(host_rdata), .busy(busy),
  .cmd(cmd), .l2_we(l2_we)
);

// File: tb/ltbl_engine_bench.sv
module ltbl_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        busy;

  int checks = 0;
  int errors = 0;

  logic [147:0] m_l2 [64];
  logic [147:0] m_aux [8];
  logic [147:0] m_rd = '0;

  always #4 clk = ~clk;

  ltbl_engine u_ltbl_engine (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy)
  );

  function automatic logic [5:0] b_hash(input logic [47:0] mac, input logic [11:0] fid);
    logic [59:0] k = {fid, mac};
    logic [5:0]  h = '0;
    for (int b = 0; b < 60; b++) h[b % 6] ^= k[b];
    return h;
  endfunction

  function automatic logic [147:0] mk_ent(input logic v, input logic mc, input logic [3:0] pt,
                                          input logic [47:0] mac, input logic [11:0] fid);
    logic [81:0] pay = {18'($urandom), $urandom, $urandom};
    return {pay, fid, mac, pt, mc, v};
  endfunction

  function automatic bit b_match(input logic [147:0] e, input logic [2:0] mt, input logic [3:0] pt);
    if (!e[0]) return 0;
    case (mt)
      3'd3: return !e[1];
      3'd4: return e[1];
      3'd5: return !e[1] && e[5:2] == pt;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic hr(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); host_addr = a; #1; d = host_rdata;
  endtask

  task automatic load_ent(input logic [147:0] e);
    for (int i = 0; i < 9; i++) hw(6'h10 + 6'(i), e[i*16 +: 16]);
    hw(6'h19, {12'h0, e[147:144]});
  endtask

  task automatic run_cmd(input logic [15:0] c, output int cyc);
    @(negedge clk); host_we = 1'b1; host_addr = 6'h00; host_wdata = c;
    @(negedge clk); host_we = 1'b0; cyc = 0;
    while (busy && cyc < 300) begin cyc++; @(negedge clk); end
  endtask

  task automatic check_rd(input string req);
    logic [15:0] r;
    for (int i = 0; i < 10; i++) begin
      hr(6'h20 + 6'(i), r);
      if (i < 9) chk(r == m_rd[i*16 +: 16], req, r, m_rd[i*16 +: 16]);
      else chk(r == {12'h0, m_rd[147:144]}, req, r, {12'h0, m_rd[147:144]});
    end
  endtask

  task automatic do_op(input logic [15:0] c, input logic [12:0] start,
                       input logic [147:0] e, input string req);
    logic [2:0]  tbl = c[2:0];
    logic        opw = c[3];
    logic [2:0]  mt  = c[6:4];
    logic [3:0]  pt  = c[11:8];
    bit          ehit = 0;
    logic [12:0] eidx = '0;
    int          elat = 1;
    int          lat;
    logic [15:0] r;
    logic [5:0]  h;
    load_ent(e);
    hw(6'h01, {3'b000, start});
    if (tbl != 3'd0) begin
      if (opw) m_aux[start[2:0]] = e;
      else m_rd = m_aux[start[2:0]];
    end else if (opw) begin
      h = b_hash(e[53:6], e[65:54]);
      if (!m_l2[h][0] || m_l2[h][65:6] == e[65:6]) begin
        m_l2[h] = e; ehit = 1; eidx = 13'(h);
      end
    end else begin
      case (mt)
        3'd0: begin
          h = b_hash(e[53:6], e[65:54]);
          if (m_l2[h][0] && m_l2[h][65:6] == e[65:6]) begin
            ehit = 1; eidx = 13'(h); m_rd = m_l2[h];
          end
        end
        3'd1: if (start < 64 && m_l2[start[5:0]][0]) begin
          ehit = 1; eidx = start; m_rd = m_l2[start[5:0]];
        end
        3'd2, 3'd3, 3'd4, 3'd5: if (start < 63) begin
          elat = 64 - int'(start);
          for (int j = int'(start) + 1; j < 64; j++) begin
            if (b_match(m_l2[j], mt, pt)) begin
              ehit = 1; eidx = 13'(j); m_rd = m_l2[j]; elat = j - int'(start) + 1;
              break;
            end
          end
        end
        default: ;
      endcase
    end
    run_cmd(c, lat);
    chk(lat == elat, {req, " R13 busy length"}, lat, elat);
    hr(6'h02, r);
    chk(r[12] == ehit, {req, " hit"}, r[12], ehit);
    chk({r[11], r[14], r[10:0]} == eidx, {req, " R3 index"}, {r[11], r[14], r[10:0]}, eidx);
    hr(6'h00, r);
    chk(r == (c & 16'h0F7F), {req, " R1 ctrl readback"}, r, c & 16'h0F7F);
    if (!opw) check_rd({req, " R11 read words"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0]  r;
    logic [147:0] ea, eb;
    logic [47:0]  mac;
    logic [11:0]  fid;
    int           lat;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) m_l2[i] = '0;
    for (int i = 0; i < 8; i++) m_aux[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    hr(6'h02, r); chk(r == 16'h0, "R3 status after reset", r, 0);
    chk(busy == 1'b0, "R4 busy after reset", busy, 0);
    hr(6'h00, r); chk(r == 16'h0, "R1 ctrl after reset", r, 0);
    hr(6'h20, r); chk(r == 16'h0, "R5 read word after reset", r, 0);

    // register widths
    hw(6'h01, 16'hFFFF); hr(6'h01, r); chk(r == 16'h1FFF, "R2 index width", r, 16'h1FFF);
    hw(6'h19, 16'hFFFF); hr(6'h19, r); chk(r == 16'h000F, "R5 tenth word", r, 16'h000F);

    // collision handling
    ea = mk_ent(1'b1, 1'b0, 4'd2, 48'h02AA_0000_0001, 12'h005);
    eb = ea; eb[53:6] = ea[53:6] ^ 48'h41;
    do_op(16'h0008, 13'h1ABC, ea, "R6 write to empty slot");
    do_op(16'h0008, 13'h0000, eb, "R6 colliding write");
    do_op(16'h0000, 13'h0000, ea, "R7 key read hit");
    do_op(16'h0000, 13'h0000, eb, "R7 key read miss");

    // unsupported methods
    do_op(16'h0060, 13'd5, ea, "R10 method 6");
    do_op(16'h0070, 13'd5, ea, "R10 method 7");

    // other tables
    do_op(16'h0009, 13'd0, mk_ent(1'b1, 1'b1, 4'd7, 48'h1234, 12'h1), "R12 aux write");
    do_op(16'hFFFF, 13'd3, mk_ent(1'b0, 1'b1, 4'd1, 48'h5678, 12'h2), "R12 aux write raw ctrl R1");
    do_op(16'h0002, 13'd0, ea, "R12 aux read");

    // random fill and mixed operations
    for (int n = 0; n < 110; n++) begin
      int kind = int'($urandom % 8);
      logic [15:0] c;
      logic [12:0] st = 13'($urandom % 72);
      mac = 48'h02AA_0000_0000 | 48'($urandom % 24);
      fid = 12'($urandom % 2);
      ea = mk_ent(1'($urandom % 4 != 0), 1'($urandom % 3 == 0), 4'($urandom % 4), mac, fid);
      case (kind)
        0, 1: c = 16'h0008;
        2: c = 16'h0000;
        3: c = 16'h0010;
        4, 5: c = {4'h0, 4'($urandom % 4), 1'b0, 3'(2 + $urandom % 4), 4'h0};
        6: c = {12'h0, 1'b1, 3'(1 + $urandom % 7)};
        default: c = {12'h0, 1'b0, 3'(1 + $urandom % 7)};
      endcase
      do_op(c, st, ea, (kind < 2) ? "R6 random write" : (kind == 2) ? "R7 random key read" :
            (kind == 3) ? "R8 random index read" : (kind < 6) ? "R9 random scan" : "R12 random aux");
    end

    // directed index and scan corners
    do_op(16'h0010, 13'd70, ea, "R8 index beyond table");
    do_op(16'h0010, 13'(b_hash(48'h02AA_0000_0003, 12'h0)), ea, "R8 index read");
    do_op(16'h0020, 13'd63, ea, "R9 scan from last slot");
    do_op(16'h0020, 13'd0, ea, "R9 scan any");
    do_op(16'h0030, 13'd10, ea, "R9 scan unicast");
    do_op(16'h0040, 13'd0, ea, "R9 scan multicast");
    do_op(16'h0150, 13'd0, ea, "R9 scan unicast port 1");
    do_op(16'h0F50, 13'd0, ea, "R9 scan unicast port 15");

    // control write while busy is dropped
    hw(6'h01, 13'd0);
    @(negedge clk); host_we = 1'b1; host_addr = 6'h00; host_wdata = 16'h0020;
    @(negedge clk); host_addr = 6'h00; host_wdata = 16'h0009;
    @(negedge clk); host_we = 1'b0;
    lat = 0;
    while (busy && lat < 300) begin lat++; @(negedge clk); end
    hr(6'h00, r); chk(r == 16'h0020, "R4 ctrl unchanged by busy write", r, 16'h0020);
    do_op(16'h0002, 13'd0, ea, "R4 aux untouched by dropped write");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end
endmodule